// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a 64-bit multiplexed address/data bus. The bus is treated as two lanes. The lower lane covers address/data bits 31:0 and command/byte-enable bits 3:0. The upper lane covers address/data bits 63:32 and command/byte-enable bits 7:4. The block watches four active-low strobes: the frame strobe, the initiator-ready strobe, the target-ready strobe and the 64-bit request. From these it works out when an address phase or a data phase launches parity. Each parity bit is presented, or compared, exactly one clock after the event that launches it.

A role input selects between two modes. In driving mode the block places the computed parity bits on its outputs and raises their output enables. In receiving mode it keeps the enables low. It then compares the parity bit arriving in the next cycle against the value computed from the bus sampled at the launch edge, and flags a mismatch separately for each lane. A read/write input decides which ready strobe launches data-phase parity.

Top module: `bus_parity_unit`

## Requirements
- R1: The lower parity bit equals the XOR of ad[31:0] and cbe[3:0], so that those 36 bits plus the parity bit hold an even count of ones.
- R2: The upper parity bit equals the XOR of ad[63:32] and cbe[7:4], so that those 36 bits plus the parity bit hold an even count of ones.
- R3: Address-phase detection. Suppose no transaction is open, both parity enables are low, and frame_n is sampled low at a clock edge. Then that edge is an address phase. In driving mode, the lower enable is high in the next cycle and the lower parity of the bus sampled at that edge is on the output.
- R4: The 64-bit request flag (req64_n) is sampled at the address phase. If it was high, the upper lane stays inactive for the whole transaction: its enable stays low, and its error flag never rises, whatever the upper parity input carries. If it was low, the upper lane follows the same timing as the lower lane.
- R5: In a write transaction (wr_i=1), each clock edge with irdy_n low launches data-phase parity for the next cycle. A low trdy_n alone launches nothing.
- R6: In a read transaction (wr_i=0), each clock edge with trdy_n low launches data-phase parity for the next cycle. A low irdy_n alone launches nothing.
- R7: Parity stays driven through the cycle after the edge where irdy_n and trdy_n are both low, which completes the data phase. The enable drops after that cycle unless a new launch occurs.
- R8: The transaction closes on a completing edge at which frame_n is high. Ready strobes after that point launch nothing until the next address phase.
- R9: In receiving mode the enables stay low. After a launch edge, the parity input sampled at the following edge is compared with the parity computed at the launch edge. On a mismatch the lane's error flag is high for one cycle, starting two edges after the launch.
- R10: While rst_n is low at a clock edge, every enable and error flag is cleared and the transaction state returns to idle.
- R11: While either parity enable is high, a low frame_n is not taken as an address phase. The address phase is recognised at the first edge after both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 64 | Multiplexed address/data bus as seen at the pins |
| cbe_i | input | 8 | Command/byte-enable bus as seen at the pins |
| frame_n_i | input | 1 | Frame strobe, active low |
| irdy_n_i | input | 1 | Initiator-ready strobe, active low |
| trdy_n_i | input | 1 | Target-ready strobe, active low |
| req64_n_i | input | 1 | 64-bit transfer request, active low |
| drive_i | input | 1 | 1: this side drives the parity bits; 0: this side checks them |
| wr_i | input | 1 | 1: write transaction; 0: read transaction |
| par_lo_i | input | 1 | Lower-lane parity bit as seen at the pin |
| par_hi_i | input | 1 | Upper-lane parity bit as seen at the pin |
| par_lo_o | output | 1 | Lower-lane parity to drive |
| par_hi_o | output | 1 | Upper-lane parity to drive |
| par_lo_oe_o | output | 1 | Output enable for the lower parity bit |
| par_hi_oe_o | output | 1 | Output enable for the upper parity bit |
| err_lo_o | output | 1 | Lower-lane parity mismatch pulse |
| err_hi_o | output | 1 | Upper-lane parity mismatch pulse |

## Verification
A stale transaction state would appear one cycle later as an enable that rises on ready strobes after the frame strobe closed, or as one that fails to rise after a fresh address phase. A wrong 64-bit latch would show at once on the upper enable and the upper error flag for the whole transaction. Parity computed over the wrong sample, or over the wrong lane bits, appears on the parity output in the cycle after launch. A checker that compares in the wrong cycle produces a missing or misplaced error pulse two edges after launch. A missing release guard would let an address phase fire while an enable is still high, and the result would show one cycle later.

// File: rtl/bpu_pkg.sv
// Package: shared types for the bus parity unit.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package bpu_pkg;

    // Transaction tracking state: no open transaction, or one in progress.
    typedef enum logic {
        TXN_IDLE = 1'b0,
        TXN_OPEN = 1'b1
    } txn_state_e;

    // Number of parity lanes on the bus (lower and upper).
    localparam int unsigned BPU_LANES = 2;

endpackage

// File: rtl/bpu_phase_tracker.sv
// Module: bpu_phase_tracker
// Follows the active-low bus strobes and decides at which clock edges
// parity is launched: the address phase (frame first seen low while idle
// and no parity is driven) and data-phase strobes (irdy for writes, trdy
// for reads). Latches whether the transaction asked for the upper lane.
// Assumes: strobes are already synchronous to clk; reset is synchronous.
module bpu_phase_tracker
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_i,
    input  logic irdy_n_i,
    input  logic trdy_n_i,
    input  logic req64_n_i,
    input  logic wr_i,
    input  logic lanes_busy_i,
    output logic addr_evt_o,
    output logic launch_o,
    output logic wide_o,
    output logic open_o
);

    txn_state_e state_q;
    logic       wide_q;
    logic       strobe_hit;
    logic       phase_done;

    // Address phase: idle, frame low, and both parity enables released.
    always_comb begin
        addr_evt_o = (state_q == TXN_IDLE) && !frame_n_i && !lanes_busy_i;
    end

    // Data-phase launch strobe chosen by transfer direction.
    always_comb begin
        if (wr_i) begin
            strobe_hit = (state_q == TXN_OPEN) && !irdy_n_i;
        end else begin
            strobe_hit = (state_q == TXN_OPEN) && !trdy_n_i;
        end
    end

    // A data phase completes when both ready strobes are low.
    always_comb begin
        phase_done = (state_q == TXN_OPEN) && !irdy_n_i && !trdy_n_i;
    end

    // Launch and effective lane width for this edge.
    always_comb begin
        launch_o = addr_evt_o || strobe_hit;
        wide_o   = addr_evt_o ? !req64_n_i : wide_q;
        open_o   = (state_q == TXN_OPEN);
    end

    // Transaction state and 64-bit latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXN_IDLE;
            wide_q  <= 1'b0;
        end else if (addr_evt_o) begin
            state_q <= TXN_OPEN;
            wide_q  <= !req64_n_i;
        end else if (phase_done && frame_n_i) begin
            state_q <= TXN_IDLE;
        end
    end

    // R8: an accepted address phase always opens a transaction.
    a_r8_open_after_addr: assert property (
        @(posedge clk) disable iff (!rst_n)
        addr_evt_o |=> open_o
    );

endmodule

// File: rtl/bpu_lane.sv
// Module: bpu_lane
// One parity lane. Computes even parity over its slice of address/data
// and command/byte-enable bits. In driving mode it registers the parity
// and its enable for the cycle after a launch. In receiving mode it
// stores the expected parity and compares it with the incoming bit one
// edge later, giving a one-cycle error pulse on mismatch.
// Assumes: launch_i is already qualified for this lane.
module bpu_lane #(
    parameter int unsigned LANE_AD_W = 32,
    parameter int unsigned LANE_BE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANE_AD_W-1:0] ad_i,
    input  logic [LANE_BE_W-1:0] be_i,
    input  logic                 launch_i,
    input  logic                 drive_i,
    input  logic                 par_i,
    output logic                 par_o,
    output logic                 oe_o,
    output logic                 err_o
);

    localparam int unsigned SLICE_W = LANE_AD_W + LANE_BE_W;

    logic [SLICE_W-1:0] slice;
    logic               even_bit;
    logic               par_q;
    logic               oe_q;
    logic               exp_q;
    logic               pend_q;
    logic               err_q;

    // Gather the lane's covered bits and reduce them to one parity bit.
    always_comb begin
        slice    = {be_i, ad_i};
        even_bit = ^slice;
    end

    // Driving path: parity value and enable for the cycle after launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= launch_i && drive_i;
            if (launch_i && drive_i) begin
                par_q <= even_bit;
            end
        end
    end

    // Receiving path: hold expected parity, compare one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= 1'b0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= launch_i && !drive_i;
            if (launch_i && !drive_i) begin
                exp_q <= even_bit;
            end
            err_q <= pend_q && (par_i != exp_q);
        end
    end

    // Output assignments.
    always_comb begin
        par_o = par_q;
        oe_o  = oe_q;
        err_o = err_q;
    end

    // R1 / R2: a driven parity bit makes the previous-cycle slice even.
    a_r1_r2_driven_even: assert property (
        @(posedge clk) disable iff (!rst_n)
        oe_o |-> (par_o == $past(^{be_i, ad_i}))
    );

    // R9: an error pulse only follows a receive-mode launch two edges back.
    a_r9_err_after_rx_launch: assert property (
        @(posedge clk) disable iff (!rst_n)
        err_o |-> $past(launch_i && !drive_i, 2)
    );

endmodule

// File: rtl/bus_parity_unit.sv
// Module: bus_parity_unit (top)
// Parity generator/checker for a 64-bit multiplexed bus split into two
// lanes. The phase tracker picks launch edges; one bpu_lane per lane
// drives or checks parity one clock later. The upper lane launches only
// when the transaction requested 64-bit transfers.
// Assumes: pad tri-state control sits outside; enables feed it directly.
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int unsigned LANE_AD_W = 32,
    parameter int unsigned LANE_BE_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [BPU_LANES*LANE_AD_W-1:0]  ad_i,
    input  logic [BPU_LANES*LANE_BE_W-1:0]  cbe_i,
    input  logic                            frame_n_i,
    input  logic                            irdy_n_i,
    input  logic                            trdy_n_i,
    input  logic                            req64_n_i,
    input  logic                            drive_i,
    input  logic                            wr_i,
    input  logic                            par_lo_i,
    input  logic                            par_hi_i,
    output logic                            par_lo_o,
    output logic                            par_hi_o,
    output logic                            par_lo_oe_o,
    output logic                            par_hi_oe_o,
    output logic                            err_lo_o,
    output logic                            err_hi_o
);

    localparam int unsigned LANES = BPU_LANES;

    logic             addr_evt;
    logic             launch;
    logic             wide;
    logic             txn_open;
    logic             lanes_busy;
    logic [LANES-1:0] lane_launch;
    logic [LANES-1:0] lane_par_in;
    logic [LANES-1:0] lane_par;
    logic [LANES-1:0] lane_oe;
    logic [LANES-1:0] lane_err;

    // Any driven enable blocks recognition of a new address phase.
    always_comb begin
        lanes_busy = |lane_oe;
    end

    // Incoming parity pins gathered per lane.
    always_comb begin
        lane_par_in = {par_hi_i, par_lo_i};
    end

    bpu_phase_tracker u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n_i),
        .irdy_n_i     (irdy_n_i),
        .trdy_n_i     (trdy_n_i),
        .req64_n_i    (req64_n_i),
        .wr_i         (wr_i),
        .lanes_busy_i (lanes_busy),
        .addr_evt_o   (addr_evt),
        .launch_o     (launch),
        .wide_o       (wide),
        .open_o       (txn_open)
    );

    // One lane per slice; lanes above the lowest need a 64-bit request.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            always_comb lane_launch[g] = launch;
        end else begin : g_ext
            always_comb lane_launch[g] = launch && wide;
        end

        bpu_lane #(
            .LANE_AD_W (LANE_AD_W),
            .LANE_BE_W (LANE_BE_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .ad_i     (ad_i[g*LANE_AD_W +: LANE_AD_W]),
            .be_i     (cbe_i[g*LANE_BE_W +: LANE_BE_W]),
            .launch_i (lane_launch[g]),
            .drive_i  (drive_i),
            .par_i    (lane_par_in[g]),
            .par_o    (lane_par[g]),
            .oe_o     (lane_oe[g]),
            .err_o    (lane_err[g])
        );
    end

    // Lane outputs mapped to named pins.
    always_comb begin
        par_lo_o    = lane_par[0];
        par_hi_o    = lane_par[1];
        par_lo_oe_o = lane_oe[0];
        par_hi_oe_o = lane_oe[1];
        err_lo_o    = lane_err[0];
        err_hi_o    = lane_err[1];
    end

    // R11: an address phase is never accepted while a parity bit is driven.
    a_r11_no_addr_while_driving: assert property (
        @(posedge clk) disable iff (!rst_n)
        addr_evt |-> !(par_lo_oe_o || par_hi_oe_o)
    );

    // R4: the upper lane is never driven without the lower lane.
    a_r4_hi_oe_needs_lo_oe: assert property (
        @(posedge clk) disable iff (!rst_n)
        par_hi_oe_o |-> par_lo_oe_o
    );

    // R8: a launch outside an address phase needs an open transaction.
    a_r8_launch_needs_txn: assert property (
        @(posedge clk) disable iff (!rst_n)
        (launch && !addr_evt) |-> txn_open
    );

endmodule

// File: tb/bus_parity_unit_tb_top.sv
// Scoreboard bench: the driver task applies one cycle of stimulus at the
// falling edge, runs a requirement-level model and pushes the expected
// outputs; the monitor pops and compares shortly after each rising edge.
module bus_parity_unit_tb_top;

    typedef struct {
        logic  oe_lo;
        logic  oe_hi;
        logic  p_lo;
        logic  p_hi;
        logic  e_lo;
        logic  e_hi;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe = '0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, req64_n = 1'b1;
    logic        drv = 1'b1, wr = 1'b1, pin_lo = 1'b0, pin_hi = 1'b0;
    logic        par_lo, par_hi, oe_lo, oe_hi, err_lo, err_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // model state
    bit m_open = 0, m_wide = 0, m_oe_lo = 0, m_oe_hi = 0;
    bit m_p_lo = 0, m_p_hi = 0, m_pend_lo = 0, m_pend_hi = 0;
    bit m_x_lo = 0, m_x_hi = 0, m_e_lo = 0, m_e_hi = 0;

    always #10 clk = ~clk;

    bus_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe),
        .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
        .req64_n_i(req64_n), .drive_i(drv), .wr_i(wr),
        .par_lo_i(pin_lo), .par_hi_i(pin_hi),
        .par_lo_o(par_lo), .par_hi_o(par_hi),
        .par_lo_oe_o(oe_lo), .par_hi_oe_o(oe_hi),
        .err_lo_o(err_lo), .err_hi_o(err_hi)
    );

    function automatic bit plo(logic [63:0] a, logic [7:0] b);
        return ^{a[31:0], b[3:0]};
    endfunction

    function automatic bit phi(logic [63:0] a, logic [7:0] b);
        return ^{a[63:32], b[7:4]};
    endfunction

    // Apply one cycle of stimulus and push the expected outputs.
    task automatic cyc(input bit rst, input bit f, input bit ir, input bit tr,
                       input bit r64, input bit d, input bit w,
                       input logic [63:0] a, input logic [7:0] b,
                       input bit pl, input bit ph, input string tag);
        bit addr, strobe, launch, weff, done_ph;
        exp_t e;
        @(negedge clk);
        rst_n = !rst; frame_n = f; irdy_n = ir; trdy_n = tr; req64_n = r64;
        drv = d; wr = w; ad = a; cbe = b; pin_lo = pl; pin_hi = ph;
        if (rst) begin
            m_open = 0; m_wide = 0; m_oe_lo = 0; m_oe_hi = 0;
            m_pend_lo = 0; m_pend_hi = 0; m_e_lo = 0; m_e_hi = 0;
        end else begin
            addr    = !m_open && !f && !m_oe_lo && !m_oe_hi;
            strobe  = m_open && (w ? !ir : !tr);
            launch  = addr || strobe;
            weff    = addr ? !r64 : m_wide;
            done_ph = m_open && !ir && !tr;
            m_e_lo = m_pend_lo && (pl != m_x_lo);
            m_e_hi = m_pend_hi && (ph != m_x_hi);
            m_oe_lo = launch && d;
            m_oe_hi = launch && weff && d;
            if (m_oe_lo) m_p_lo = plo(a, b);
            if (m_oe_hi) m_p_hi = phi(a, b);
            m_pend_lo = launch && !d;
            m_pend_hi = launch && weff && !d;
            if (m_pend_lo) m_x_lo = plo(a, b);
            if (m_pend_hi) m_x_hi = phi(a, b);
            if (addr) begin
                m_open = 1; m_wide = !r64;
            end else if (done_ph && f) begin
                m_open = 0;
            end
        end
        e.oe_lo = m_oe_lo; e.oe_hi = m_oe_hi; e.p_lo = m_p_lo; e.p_hi = m_p_hi;
        e.e_lo = m_e_lo; e.e_hi = m_e_hi; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc(0, 1, 1, 1, 1, drv, wr, 64'h0, 8'h0, 0, 0, tag);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                bit bad;
                e = sb.pop_front();
                checks++;
                bad = (oe_lo !== e.oe_lo) || (oe_hi !== e.oe_hi) ||
                      (err_lo !== e.e_lo) || (err_hi !== e.e_hi) ||
                      (e.oe_lo && par_lo !== e.p_lo) ||
                      (e.oe_hi && par_hi !== e.p_hi);
                if (bad) begin
                    errors++;
                    $display("FAIL %s: got oe=%b%b par=%b%b err=%b%b exp oe=%b%b par=%b%b err=%b%b",
                             e.tag, oe_hi, oe_lo, par_hi, par_lo, err_hi, err_lo,
                             e.oe_hi, e.oe_lo, e.p_hi, e.p_lo, e.e_hi, e.e_lo);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] a0, a1, a2;
        logic [7:0]  b0, b1;
        // R10: reset clears everything even with strobes low.
        cyc(1, 0, 0, 0, 0, 1, 1, 64'hFFFF_0000_1234_5678, 8'hA5, 0, 0, "R10 reset");
        cyc(1, 0, 0, 0, 0, 1, 1, 64'h1, 8'h1, 0, 0, "R10 reset");
        idle("R10 idle after reset");

        // 64-bit write, driving: R3 address, R1/R2 lanes, R5 irdy keyed, R7 hold.
        for (int k = 0; k < 4; k++) begin
            a0 = {$urandom, $urandom}; a1 = {$urandom, $urandom}; a2 = {$urandom, $urandom};
            b0 = 8'($urandom); b1 = 8'($urandom);
            cyc(0, 0, 1, 1, 0, 1, 1, a0, b0, 0, 0, "R3 R1 R2 addr 64");
            cyc(0, 0, 1, 0, 0, 1, 1, a1, b1, 0, 0, "R5 trdy alone on write");
            cyc(0, 0, 0, 1, 0, 1, 1, a1, b1, 0, 0, "R5 irdy launch");
            cyc(0, 1, 0, 0, 0, 1, 1, a2, b0, 0, 0, "R7 R8 final phase");
            cyc(0, 1, 0, 1, 0, 1, 1, a0, b1, 0, 0, "R7 R8 after end");
            idle("R8 idle");
        end

        // 32-bit read, driving: R6 trdy keyed, R4 upper lane idle.
        a0 = 64'hDEAD_BEEF_0000_0001; b0 = 8'h3C;
        cyc(0, 0, 1, 1, 1, 1, 0, a0, b0, 0, 0, "R4 R3 addr 32");
        cyc(0, 0, 0, 1, 1, 1, 0, a0, b0, 0, 0, "R6 irdy alone on read");
        cyc(0, 0, 1, 0, 1, 1, 0, 64'hF0F0_0000_0000_0007, 8'h1F, 0, 0, "R6 trdy launch");
        cyc(0, 0, 0, 0, 1, 1, 0, 64'h0000_0001_8000_0000, 8'h2, 0, 0, "R7 R4 complete");
        // R11: frame low immediately while enable still high.
        cyc(0, 1, 0, 0, 1, 1, 0, 64'h5, 8'h0, 0, 0, "R8 R11 end");
        cyc(0, 0, 1, 1, 0, 1, 1, 64'h7777_0000_0000_0003, 8'hF0, 0, 0, "R11 blocked addr");
        cyc(0, 0, 1, 1, 0, 1, 1, 64'h7777_0000_0000_0003, 8'hF0, 0, 0, "R11 accepted addr");
        cyc(0, 1, 0, 0, 0, 1, 1, 64'h9, 8'h9, 0, 0, "R7 single phase");
        idle("R8 idle");
        idle("R8 idle");

        // Receive mode 64-bit: R9 checks with correct and wrong parity.
        for (int k = 0; k < 4; k++) begin
            a0 = {$urandom, $urandom}; b0 = 8'($urandom);
            a1 = {$urandom, $urandom}; b1 = 8'($urandom);
            cyc(0, 0, 1, 1, 0, 0, 1, a0, b0, 0, 0, "R9 rx addr");
            cyc(0, 0, 0, 1, 0, 0, 1, a1, b1, plo(a0, b0) ^ k[0], phi(a0, b0) ^ k[1], "R9 rx addr parity");
            cyc(0, 1, 0, 0, 0, 0, 1, a1, b1, plo(a1, b1), phi(a1, b1) ^ 1'b1, "R9 rx data parity");
            cyc(0, 1, 1, 1, 1, 0, 1, 64'h0, 8'h0, plo(a1, b1) ^ k[0], phi(a1, b1), "R9 rx final parity");
            idle("R9 pulse one cycle");
            idle("R9 idle");
        end

        // Receive mode 32-bit: R4 upper errors suppressed.
        a0 = 64'h1234_5678_9ABC_DEF0; b0 = 8'h81;
        cyc(0, 0, 1, 1, 1, 0, 0, a0, b0, 0, 0, "R4 rx addr 32");
        cyc(0, 1, 0, 0, 1, 0, 0, a0, b0, plo(a0, b0), ~phi(a0, b0), "R4 rx hi ignored");
        cyc(0, 1, 1, 1, 1, 0, 0, 64'h0, 8'h0, ~plo(a0, b0), 1, "R4 R9 lo err");
        idle("R4 R9 pulse");
        idle("R9 idle");

        // R10: reset during an open transaction returns to idle.
        cyc(0, 0, 1, 1, 0, 1, 1, 64'hAB, 8'h1, 0, 0, "R3 addr before reset");
        cyc(1, 0, 0, 1, 0, 1, 1, 64'hCD, 8'h2, 0, 0, "R10 mid reset");
        cyc(0, 1, 0, 1, 0, 1, 1, 64'hEF, 8'h3, 0, 0, "R10 strobe after reset ignored");
        idle("R10 idle");
        idle("R10 idle");

        @(posedge clk);
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule